// File: doc/BRIEF.md
# Security Code Validation Sequencer

This block watches the serial access to a protected key held in a bit-addressed memory. It decides whether a host has proved that it knows the key. The host walks the bit address up to a 16-bit key and clocks its candidate key in one bit per serial clock. The block keeps a sticky mismatch record while the bits arrive. In the counter-backed variant, the host then moves on to the first 1 bit of the 8-bit attempts byte that follows the key and writes a 0 there. That write spends one attempt. If every key bit matched, the comparison flag sets at the moment the program-control line rises for that write. The block then allows the following erase of the attempts byte, which restores eight tries. A failed entry leaves the erase blocked.

Serial clock edges arrive as single-cycle strobes in the system clock domain. The address reset also arrives as a strobe. The key and counter bits come from the memory that sits beside the block. A compare-only variant, selected by a parameter, sets its flag at the comparison of the last key bit. It has no attempts counter.

The sequencer has six states:
- IDLE: no entry in progress.
- ENTER: key bits are being compared.
- ARMED: the key is complete and the block waits for the counter write.
- WRITE: the counter write is under way.
- POST: the write is done and the block waits for the erase.
- ERASE: the erase is under way.

Transitions:
- IDLE to ENTER: comparison of the first key bit.
- ENTER to ENTER: the first key bit is compared again.
- ENTER to ARMED: last key bit, counter variant.
- ENTER to IDLE: last key bit, compare-only variant.
- ARMED to WRITE: program-control rise on the first 1 of the counter.
- ARMED to IDLE: program-control rise anywhere else, or a serial fall outside the counter byte.
- WRITE to POST: serial fall.
- POST to ERASE: program-control rise.
- POST to IDLE: serial rise while program control is low (abort).
- ERASE to IDLE: serial fall.
- Any state to IDLE: address reset.

Top module: `svq_validator`

## Requirements
- R1: The input bit is captured on a serial rising strobe and compared with the stored bit on the next serial falling strobe. A change of the input between the two strobes has no effect on the result.
- R2: One mismatching bit anywhere in the 16 key bits makes the whole entry fail. The counter write that follows does not set the flag.
- R3: With a fully matching key, the flag is 0 until program control rises while the address points at the first 1 of the attempts byte. The flag reads 1 from the cycle after that rise.
- R4: A counter write at a position that is not the first 1 does not set the flag. Here ctr_bits[i] is the bit at address KEY_BASE+16+i, and "first" means the lowest i.
- R5: erase_ok is 1 during the erase phase when the flag is set. It stays 0 when the flag is clear.
- R6: locked is 1 exactly when all eight attempts bits are 0. While locked is 1 the flag cannot set. A correct key on the last remaining attempt still sets the flag.
- R7: A serial rising strobe with program control low after the counter write abandons the sequence. A later program-control rise then gives no erase_ok.
- R8: In the compare-only variant, the flag sets after the falling strobe of the last key bit when all 16 bits matched. It stays 0 otherwise. locked is always 0 in that variant.
- R9: After reset the flag is 0. Once set, it stays 1 through address resets and failed entries until the next reset.
- R10: An address reset discards any mismatch recorded by an earlier partial entry, so a following correct entry succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| addr_clear | input | 1 | Strobe: the bit address counter was reset |
| sclk_rise | input | 1 | Strobe: serial clock rising edge |
| sclk_fall | input | 1 | Strobe: serial clock falling edge |
| bit_addr | input | ADDR_W | Current bit address |
| din | input | 1 | Serial input bit from the host |
| key_bit | input | 1 | Stored key bit at bit_addr |
| prog | input | 1 | Program-control level |
| ctr_bits | input | CTR_BITS | Attempts byte, bit i at address KEY_BASE+16+i |
| valid_flag | output | 1 | Sticky comparison flag |
| locked | output | 1 | All attempts used up |
| erase_ok | output | 1 | Erase of the attempts byte is allowed now |

## Verification
The bench changes the input bit between the rising and falling strobes. A design that compared at the wrong edge would pass a wrong key or reject a right one. It places a single wrong bit in the middle of a key and then writes the counter. A design that only checked the last bit would raise the flag.

It writes at a counter position above a remaining 1 bit. It also raises the serial clock with program control low after the write. A design that skipped either rule would still grant the erase or set the flag.

It clears the address after a broken partial entry and checks that a later correct entry succeeds. It also checks that the eighth and last attempt still works. Finally, it checks that the flag survives address resets and later failures, and only power-on reset clears it.

// File: rtl/svq_pkg.sv
package svq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_ARMED,
        ST_WRITE,
        ST_POST,
        ST_ERASE
    } svq_state_e;
endpackage

// File: rtl/svq_keycmp.sv
// Captures host bits on serial rise, compares on serial fall, keeps a sticky miss.
module svq_keycmp #(
    parameter int ADDR_W   = 14,
    parameter int KEY_BASE = 80,
    parameter int KEY_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_clear,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic              din,
    input  logic              key_bit,
    output logic              first_fall,
    output logic              last_fall,
    output logic              entry_clean,
    output logic              miss
);
    localparam logic [ADDR_W-1:0] KFIRST = ADDR_W'(KEY_BASE);
    localparam logic [ADDR_W-1:0] KLAST  = ADDR_W'(KEY_BASE + KEY_BITS - 1);

    logic in_key;
    logic din_q;
    logic miss_q;
    logic bit_bad;

    assign in_key  = (bit_addr >= KFIRST) && (bit_addr <= KLAST);
    assign bit_bad = din_q ^ key_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q  <= 1'b0;
            miss_q <= 1'b0;
        end else begin
            if (sclk_rise && in_key) din_q <= din;
            if (addr_clear) begin
                miss_q <= 1'b0;
            end else if (sclk_fall && bit_addr == KFIRST) begin
                miss_q <= bit_bad;              // entering the key restarts the record
            end else if (sclk_fall && in_key) begin
                miss_q <= miss_q | bit_bad;
            end
        end
    end

    assign first_fall  = sclk_fall && (bit_addr == KFIRST);
    assign last_fall   = sclk_fall && (bit_addr == KLAST);
    assign entry_clean = !miss_q && !bit_bad;
    assign miss        = miss_q;

    // R2: a recorded miss persists until the key is re-entered or the address resets
    p_miss_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_q && !addr_clear && !first_fall) |=> miss_q);
endmodule

// File: rtl/svq_ctrpos.sv
// Decodes the attempts byte: position of the current bit and exhaustion.
module svq_ctrpos #(
    parameter int ADDR_W      = 14,
    parameter int CTR_BASE    = 96,
    parameter int CTR_BITS    = 8,
    parameter bit USE_COUNTER = 1'b1
) (
    input  logic [ADDR_W-1:0]   bit_addr,
    input  logic [CTR_BITS-1:0] ctr_bits,
    output logic                in_ctr,
    output logic                first_one,
    output logic                locked
);
    localparam int CIDX_W = (CTR_BITS > 1) ? $clog2(CTR_BITS) : 1;
    localparam logic [ADDR_W-1:0] CFIRST = ADDR_W'(CTR_BASE);
    localparam logic [ADDR_W-1:0] CLAST  = ADDR_W'(CTR_BASE + CTR_BITS - 1);

    generate
        if (USE_COUNTER) begin : g_counter
            logic [CIDX_W-1:0] idx;
            logic              lower_ones;

            assign idx = CIDX_W'(bit_addr - CFIRST);

            always_comb begin
                lower_ones = 1'b0;
                for (int i = 0; i < CTR_BITS; i++) begin
                    if (CIDX_W'(i) < idx) lower_ones = lower_ones | ctr_bits[i];
                end
            end

            assign in_ctr    = (bit_addr >= CFIRST) && (bit_addr <= CLAST);
            assign first_one = in_ctr && ctr_bits[idx] && !lower_ones;
            assign locked    = ~|ctr_bits;
        end else begin : g_plain
            logic unused_inputs;
            assign unused_inputs = ^{ctr_bits, bit_addr};
            assign in_ctr    = 1'b0;
            assign first_one = 1'b0;
            assign locked    = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/svq_fsm.sv
// Validation state machine and sticky comparison flag.
module svq_fsm
    import svq_pkg::*;
#(
    parameter bit USE_COUNTER = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_clear,
    input  logic sclk_rise,
    input  logic sclk_fall,
    input  logic prog,
    input  logic first_fall,
    input  logic last_fall,
    input  logic entry_clean,
    input  logic miss,
    input  logic in_ctr,
    input  logic first_one,
    input  logic locked,
    output logic valid_flag,
    output logic erase_ok
);
    svq_state_e state_q, state_d;
    logic       prog_q;
    logic       prog_rise;
    logic       flag_q;
    logic       set_flag;

    assign prog_rise = prog && !prog_q;

    always_comb begin
        state_d = state_q;
        if (addr_clear) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (first_fall) state_d = ST_ENTER;
                ST_ENTER: begin
                    if (first_fall)     state_d = ST_ENTER;
                    else if (last_fall) state_d = USE_COUNTER ? ST_ARMED : ST_IDLE;
                end
                ST_ARMED: begin
                    if (prog_rise)                 state_d = (in_ctr && first_one) ? ST_WRITE : ST_IDLE;
                    else if (sclk_fall && !in_ctr) state_d = ST_IDLE;
                end
                ST_WRITE: if (sclk_fall) state_d = ST_POST;
                ST_POST: begin
                    if (prog_rise)              state_d = ST_ERASE;
                    else if (sclk_rise && !prog) state_d = ST_IDLE;   // abort
                end
                ST_ERASE: if (sclk_fall) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        if (USE_COUNTER) begin
            set_flag = (state_q == ST_ARMED) && !addr_clear && prog_rise &&
                       in_ctr && first_one && !miss && !locked;
        end else begin
            set_flag = (state_q == ST_ENTER) && !addr_clear && last_fall && entry_clean;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prog_q  <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prog_q  <= prog;
            if (set_flag) flag_q <= 1'b1;
        end
    end

    always_comb begin
        valid_flag = flag_q;
        erase_ok   = (state_q == ST_ERASE) && flag_q;
    end

    // R9: once set, the flag only falls with reset
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> flag_q);
    // R6: an exhausted counter freezes the flag at 0
    p_lock_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && locked) |=> !flag_q);
    // R7: raising the serial clock with program low after the write abandons the run
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST && sclk_rise && !prog && !prog_rise && !addr_clear) |=> (state_q == ST_IDLE && !erase_ok));

    generate
        if (USE_COUNTER) begin : g_chk_cnt
            // R3: the flag can only rise on a program-control rise
            p_flag_on_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (!flag_q && !prog_rise) |=> !flag_q);
        end else begin : g_chk_cmp
            // R8: the flag can only rise on the last key bit comparison
            p_flag_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!flag_q && !last_fall) |=> !flag_q);
        end
    endgenerate
endmodule

// File: rtl/svq_validator.sv
module svq_validator #(
    parameter int ADDR_W      = 14,
    parameter int KEY_BASE    = 80,
    parameter int KEY_BITS    = 16,
    parameter int CTR_BITS    = 8,
    parameter bit USE_COUNTER = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_clear,
    input  logic                sclk_rise,
    input  logic                sclk_fall,
    input  logic [ADDR_W-1:0]   bit_addr,
    input  logic                din,
    input  logic                key_bit,
    input  logic                prog,
    input  logic [CTR_BITS-1:0] ctr_bits,
    output logic                valid_flag,
    output logic                locked,
    output logic                erase_ok
);
    localparam int CTR_BASE = KEY_BASE + KEY_BITS;

    logic first_fall, last_fall, entry_clean, miss;
    logic in_ctr, first_one;

    svq_keycmp #(
        .ADDR_W  (ADDR_W),
        .KEY_BASE(KEY_BASE),
        .KEY_BITS(KEY_BITS)
    ) u_keycmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_clear (addr_clear),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .bit_addr   (bit_addr),
        .din        (din),
        .key_bit    (key_bit),
        .first_fall (first_fall),
        .last_fall  (last_fall),
        .entry_clean(entry_clean),
        .miss       (miss)
    );

    svq_ctrpos #(
        .ADDR_W     (ADDR_W),
        .CTR_BASE   (CTR_BASE),
        .CTR_BITS   (CTR_BITS),
        .USE_COUNTER(USE_COUNTER)
    ) u_ctrpos (
        .bit_addr (bit_addr),
        .ctr_bits (ctr_bits),
        .in_ctr   (in_ctr),
        .first_one(first_one),
        .locked   (locked)
    );

    svq_fsm #(
        .USE_COUNTER(USE_COUNTER)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_clear (addr_clear),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .prog       (prog),
        .first_fall (first_fall),
        .last_fall  (last_fall),
        .entry_clean(entry_clean),
        .miss       (miss),
        .in_ctr     (in_ctr),
        .first_one  (first_one),
        .locked     (locked),
        .valid_flag (valid_flag),
        .erase_ok   (erase_ok)
    );
endmodule

// File: tb/svq_validator_tb_top.sv
`timescale 1ns/100ps
module svq_validator_tb_top;
    localparam int AW   = 14;
    localparam int KB   = 8;
    localparam int CB   = KB + 16;
    localparam logic [15:0] KEY = 16'hA5C3;

    typedef struct {
        string tag;
        int    sel;   // 0 flag, 1 erase_ok, 2 locked, 3 cmp flag, 4 cmp locked
        logic  exp;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_clear = 1'b0, sclk_rise = 1'b0, sclk_fall = 1'b0;
    logic [AW-1:0] addr = '0;
    logic din = 1'b0, prog = 1'b0;
    logic [7:0] ctr = 8'hFF;
    logic key_bit;
    logic flag_c, lock_c, erase_c;
    logic flag_p, lock_p, erase_p;

    item_t q[$];
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign key_bit = (int'(addr) >= KB && int'(addr) < CB) ? KEY[int'(addr) - KB] : 1'b0;

    svq_validator #(.ADDR_W(AW), .KEY_BASE(KB), .KEY_BITS(16), .CTR_BITS(8), .USE_COUNTER(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_clear(addr_clear), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .bit_addr(addr), .din(din), .key_bit(key_bit),
        .prog(prog), .ctr_bits(ctr), .valid_flag(flag_c), .locked(lock_c), .erase_ok(erase_c));

    svq_validator #(.ADDR_W(AW), .KEY_BASE(KB), .KEY_BITS(16), .CTR_BITS(8), .USE_COUNTER(1'b0)) dut_p (
        .clk(clk), .rst_n(rst_n), .addr_clear(addr_clear), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .bit_addr(addr), .din(din), .key_bit(key_bit),
        .prog(prog), .ctr_bits(ctr), .valid_flag(flag_p), .locked(lock_p), .erase_ok(erase_p));

    // monitor: pops expectations and compares against live outputs
    always @(posedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic act;
            it = q.pop_front();
            case (it.sel)
                0: act = flag_c;
                1: act = erase_c;
                2: act = lock_c;
                3: act = flag_p;
                default: act = lock_p;
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_out(input string tag, input int sel, input logic exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic pulse_rise();
        @(negedge clk) sclk_rise = 1'b1;
        @(negedge clk) sclk_rise = 1'b0;
    endtask

    task automatic pulse_fall();
        @(negedge clk) sclk_fall = 1'b1;
        @(negedge clk) sclk_fall = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        prog = 1'b0; din = 1'b0; addr = '0; ctr = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic clr_addr();
        @(negedge clk) addr_clear = 1'b1; addr = '0;
        @(negedge clk) addr_clear = 1'b0;
    endtask

    task automatic serial_bit(input logic d_rise, input logic d_fall);
        din = d_rise;
        pulse_rise();
        din = d_fall;
        pulse_fall();
        addr = addr + 1'b1;
    endtask

    // flip: index of a key bit to disturb, -1 for none; at_rise picks which strobe sees the wrong value
    task automatic enter_key(input logic [15:0] k, input int flip, input bit at_rise, input int nbits);
        clr_addr();
        for (int i = 0; i < KB; i++) serial_bit(1'b0, 1'b0);
        for (int i = 0; i < nbits; i++) begin
            logic dr, df;
            dr = k[i]; df = k[i];
            if (i == flip) begin
                if (at_rise) dr = ~k[i];
                else         df = ~k[i];
            end
            serial_bit(dr, df);
        end
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) serial_bit(1'b0, 1'b0);
    endtask

    task automatic write_zero();
        @(negedge clk) prog = 1'b1; din = 1'b0;
        @(negedge clk);
        pulse_rise();
        prog = 1'b0;
        pulse_fall();
        if (int'(addr) >= CB && int'(addr) < CB + 8) ctr[int'(addr) - CB] = 1'b0;
    endtask

    task automatic erase_begin();
        @(negedge clk) prog = 1'b1; din = 1'b1;
        @(negedge clk);
    endtask

    task automatic erase_end(input bit allowed);
        pulse_rise();
        prog = 1'b0;
        pulse_fall();
        if (allowed) ctr = 8'hFF;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9 reset state
        expect_out("R9 flag after reset", 0, 1'b0);
        expect_out("R5 erase_ok after reset", 1, 1'b0);
        expect_out("R6 locked with full counter", 2, 1'b0);
        expect_out("R8 compare-only flag after reset", 3, 1'b0);

        // R3 / R5 / R8: correct key, charge attempt at first one, erase restores
        enter_key(KEY, -1, 1'b0, 16);
        expect_out("R8 compare-only flag on last bit", 3, 1'b1);
        expect_out("R8 compare-only never locked", 4, 1'b0);
        expect_out("R3 flag clear before counter write", 0, 1'b0);
        write_zero();
        expect_out("R3 flag set by counter write", 0, 1'b1);
        erase_begin();
        expect_out("R5 erase allowed with flag", 1, 1'b1);
        erase_end(1'b1);
        expect_out("R5 erase_ok drops after erase", 1, 1'b0);

        // R9 sticky through address reset and failed entry
        enter_key(KEY ^ 16'h0010, -1, 1'b0, 16);
        expect_out("R9 flag survives failed entry", 0, 1'b1);
        do_reset();
        expect_out("R9 flag cleared by reset", 0, 1'b0);
        expect_out("R9 compare flag cleared by reset", 3, 1'b0);

        // R2 / R5: single wrong bit, write, erase blocked
        enter_key(KEY ^ 16'h0100, -1, 1'b0, 16);
        expect_out("R8 compare-only rejects wrong key", 3, 1'b0);
        write_zero();
        expect_out("R2 wrong bit leaves flag clear", 0, 1'b0);
        erase_begin();
        expect_out("R5 erase blocked without flag", 1, 1'b0);
        erase_end(1'b0);

        // R4: ctr now FE, first one at index 1; write at index 2 instead
        enter_key(KEY, -1, 1'b0, 16);
        advance(2);
        write_zero();
        expect_out("R4 write past first one gives no flag", 0, 1'b0);

        // R1: wrong value only after rise is ignored; ctr now FA, first one at index 1
        enter_key(KEY, 5, 1'b0, 16);
        advance(1);
        write_zero();
        expect_out("R1 bit change after rise ignored", 0, 1'b1);
        do_reset();
        enter_key(KEY, 5, 1'b1, 16);
        expect_out("R1 wrong bit at rise fails", 3, 1'b0);
        do_reset();

        // R10: broken partial entry then address reset then clean entry
        enter_key(KEY, 0, 1'b1, 4);
        enter_key(KEY, -1, 1'b0, 16);
        expect_out("R10 compare flag after address reset", 3, 1'b1);
        write_zero();
        expect_out("R10 flag after address reset", 0, 1'b1);
        do_reset();

        // R7: abort after write, erase refused
        enter_key(KEY, -1, 1'b0, 16);
        write_zero();
        serial_bit(1'b0, 1'b0);
        @(negedge clk) prog = 1'b1;
        @(negedge clk);
        expect_out("R7 aborted run gives no erase", 1, 1'b0);
        prog = 1'b0;
        do_reset();

        // R6: exhausted counter
        ctr = 8'h00;
        expect_out("R6 locked when counter empty", 2, 1'b1);
        enter_key(KEY, -1, 1'b0, 16);
        write_zero();
        expect_out("R6 flag frozen when locked", 0, 1'b0);
        do_reset();

        // R6: last remaining attempt still succeeds
        ctr = 8'h80;
        expect_out("R6 not locked with one attempt left", 2, 1'b0);
        enter_key(KEY, -1, 1'b0, 16);
        advance(7);
        write_zero();
        expect_out("R6 last attempt sets flag", 0, 1'b1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule